// File: doc/BRIEF.md
# Configuration Event Interrupt Controller

This block collects hardware events from a configuration port and turns them into one interrupt line. Each event input passes through a two-flop synchroniser and an edge detector. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. A mask register decides which status bits may drive the interrupt. A separate summary output reports whether any bit of the fixed error group is set, whatever the mask holds.

The INIT line is watched in both directions. Its falling edge sets status bit 0 and its rising edge sets status bit 1. Its live, synchronised level can also be read from a separate level register. Events that are not on the INIT line enter on `evt_i`, one wire per status bit position from 2 up to 31, and only their rising edges are captured.

The status and mask registers are guarded. They accept writes only after a fixed key has been written to the key register. A write to either of them while the guard is closed has no effect, and it raises an illegal-access flag.

The register port is a plain single-cycle port. A write takes effect at the clock edge on which `bus_we` is high. A read is combinational from `bus_addr`. This port has no back-pressure. There is no streaming data path in this block, so no valid/ready handshake appears.

Top module: `cfg_irq_ctrl`

## Requirements
- R1: After reset the status register (address 0) reads 0, the mask register (address 1) reads 0xF8F7F87F, `irq_o` is low and the guard is closed.
- R2: A rising edge on `evt_i[k]` sets status bit k, provided bit k is implemented (set in 0xF8F7F87F). The bit is set at the third rising clock edge after the input changes. Unimplemented status bits, and unimplemented mask bits, always read 0.
- R3: A falling edge on `init_i` sets status bit 0, and a rising edge sets status bit 1. If `init_i` is already high when reset ends, bit 1 is not set.
- R4: Writing to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R5: If an event edge and a clear of the same status bit arrive at the same clock edge, the bit stays set.
- R6: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks its event.
- R7: `err_o` is high exactly when some status bit inside 0x00F0F860 is set.
- R8: Writes to addresses 0 and 1 are ignored until 0x757BDF0D is written to address 3. Writing any other value to address 3 has no effect. Once the guard opens, it stays open until reset.
- R9: A write to address 0 or 1 while the guard is closed sets bit 6 of the level register (address 2). Writing a 1 to bit 6 of address 2 clears that flag, and this write is accepted even while the guard is closed.
- R10: Bit 4 of the level register shows the synchronised live level of `init_i`, independent of the sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address: 0 status, 1 mask, 2 level, 3 key |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| init_i | input | 1 | Asynchronous INIT line |
| evt_i | input | 30 | Asynchronous event inputs for status bits 31 down to 2 |
| irq_o | output | 1 | Interrupt, active high |
| err_o | output | 1 | Any error-group status bit set |

## Verification
The hardest case to reach is a clear write to a status bit that lands on the same clock edge at which a fresh edge on that bit's input sets it again. Hitting this needs the write to line up exactly with the end of the three-stage synchroniser path. The bench changes the event input on a falling clock edge and lets two rising edges pass. It then raises the write strobe so that the write is sampled on the third rising edge. A second case that is hard to reach from the ports is INIT held high through reset and then unmasked. The bench sets `init_i` high before reset is released and checks that no rising-edge bit appears.

// File: rtl/cfg_irq_pkg.sv
package cfg_irq_pkg;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [DW-1:0] IMPL_BITS  = 32'hF8F7_F87F;
  localparam logic [DW-1:0] ERR_BITS   = 32'h00F0_F860;
  localparam logic [DW-1:0] UNLOCK_KEY = 32'h757B_DF0D;
  localparam int LVL_INIT_BIT    = 4;
  localparam int LVL_ILLEGAL_BIT = 6;
  typedef enum logic [AW-1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_LEVEL  = 2'd2,
    A_KEY    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cfg_evt_sync.sv
// Two-flop synchroniser plus edge detector per bit. FALL_SEL picks falling
// edge detection for a bit; all others detect rising edges. Edges are held
// off until the pipeline has filled after reset, so a line that is already
// high at reset is not mistaken for a transition.
module cfg_evt_sync #(
  parameter int W = 32,
  parameter logic [W-1:0] FALL_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] pulse_o,
  output logic         lvl0_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [1:0]   arm_cnt;
  logic         armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      s3_q    <= '0;
      arm_cnt <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
    end
  end

  assign armed = (arm_cnt == 2'd3);

  for (genvar gi = 0; gi < W; gi++) begin : g_edge
    if (FALL_SEL[gi]) begin : g_fall
      assign pulse_o[gi] = armed & ~s2_q[gi] & s3_q[gi];
    end else begin : g_rise
      assign pulse_o[gi] = armed & s2_q[gi] & ~s3_q[gi];
    end
  end

  assign lvl0_o = s2_q[0];
endmodule

// File: rtl/cfg_sticky_bank.sv
// Sticky status bits: set wins over clear, only implemented bits exist.
module cfg_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_i) | set_i) & IMPL;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cfg_unlock_gate.sv
// Opens once the key value is written; stays open until reset.
module cfg_unlock_gate #(
  parameter int W = 32,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_we_i,
  input  logic [W-1:0] key_i,
  output logic         unlocked_o
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        open_q <= 1'b0;
    else if (key_we_i && key_i == KEY) open_q <= 1'b1;
  end

  assign unlocked_o = open_q;
endmodule

// File: rtl/cfg_irq_ctrl.sv
module cfg_irq_ctrl
  import cfg_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          init_i,
  input  logic [DW-1:2] evt_i,
  output logic          irq_o,
  output logic          err_o
);
  // Bit 0 watches INIT falling, bit 1 watches INIT rising.
  localparam logic [DW-1:0] FALL_SEL = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] raw_v, set_v, clr_v, status_q, mask_q;
  logic          init_lvl, unlocked, illegal_q;
  logic          wr_stat, wr_mask, wr_key, wr_level, wr_blocked;

  assign raw_v = {evt_i, init_i, init_i};

  cfg_evt_sync #(.W(DW), .FALL_SEL(FALL_SEL)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_v),
    .pulse_o(set_v),
    .lvl0_o (init_lvl)
  );

  assign wr_key     = bus_we && (bus_addr == A_KEY);
  assign wr_level   = bus_we && (bus_addr == A_LEVEL);
  assign wr_stat    = bus_we && (bus_addr == A_STATUS) && unlocked;
  assign wr_mask    = bus_we && (bus_addr == A_MASK) && unlocked;
  assign wr_blocked = bus_we && !unlocked &&
                      ((bus_addr == A_STATUS) || (bus_addr == A_MASK));

  cfg_unlock_gate #(.W(DW), .KEY(UNLOCK_KEY)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_we_i  (wr_key),
    .key_i     (bus_wdata),
    .unlocked_o(unlocked)
  );

  assign clr_v = wr_stat ? bus_wdata : '0;

  cfg_sticky_bank #(.W(DW), .IMPL(IMPL_BITS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .stat_o(status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= IMPL_BITS;
    else if (wr_mask) mask_q <= bus_wdata & IMPL_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                        illegal_q <= 1'b0;
    else if (wr_blocked)                               illegal_q <= 1'b1;
    else if (wr_level && bus_wdata[LVL_ILLEGAL_BIT])   illegal_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STATUS: bus_rdata = status_q;
      A_MASK:   bus_rdata = mask_q;
      A_LEVEL: begin
        bus_rdata[LVL_INIT_BIT]    = init_lvl;
        bus_rdata[LVL_ILLEGAL_BIT] = illegal_q;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = |(status_q & ~mask_q);
  assign err_o = |(status_q & ERR_BITS);
endmodule

// File: rtl/cfg_irq_ctrl_chk.sv
module cfg_irq_ctrl_chk
  import cfg_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          irq_o,
  input logic          unlocked,
  input logic          illegal_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] clr_v
);
  AST_LOCKED_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(mask_q)); // R8

  AST_GUARD_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked); // R8

  AST_BLOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[1] && !unlocked) |=> illegal_q); // R9

  AST_STATUS_FALLS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_v)) == '0)); // R4

  AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & IMPL_BITS) == IMPL_BITS) |-> !irq_o); // R6
endmodule

bind cfg_irq_ctrl cfg_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .irq_o    (irq_o),
  .unlocked (unlocked),
  .illegal_q(illegal_q),
  .mask_q   (mask_q),
  .status_q (status_q),
  .clr_v    (clr_v)
);

// File: tb/tb_cfg_irq_ctrl.sv
module tb_cfg_irq_ctrl;
  localparam logic [31:0] IMPL = 32'hF8F7_F87F;
  localparam logic [31:0] KEY  = 32'h757B_DF0D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        init_i;
  logic [31:2] evt_i;
  logic        irq_o, err_o;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] v;

  always #2 clk = ~clk;  // 250 MHz

  cfg_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_i(init_i),
    .evt_i(evt_i), .irq_o(irq_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt_i[k] = 1'b1;
    repeat (4) @(negedge clk);
    evt_i[k] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd0, v); chk("R1 status after reset", v, 32'h0);
    chk("R3 no rise bit with INIT high at reset", {31'b0, v[1]}, 32'h0);
    rd(2'd1, v); chk("R1 mask after reset", v, IMPL);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(2'd2, v); chk("R10 live INIT high", v, 32'h10);
  endtask

  task automatic t_guard;
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R8 mask write ignored while locked", v, IMPL);
    rd(2'd2, v); chk("R9 illegal flag set", {31'b0, v[6]}, 32'h1);
    wr(2'd2, 32'h40);
    rd(2'd2, v); chk("R9 illegal flag cleared", {31'b0, v[6]}, 32'h0);
    wr(2'd3, 32'h1234_5678);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R8 wrong key keeps guard closed", v, IMPL);
    wr(2'd2, 32'h40);
    wr(2'd3, KEY);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R8 mask written after unlock", v, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R2 unimplemented mask bits read 0", v, IMPL);
    rd(2'd2, v); chk("R9 no flag after unlock", {31'b0, v[6]}, 32'h0);
  endtask

  task automatic t_init;
    @(negedge clk); init_i = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R3 INIT fall sets bit 0", v, 32'h1);
    rd(2'd2, v); chk("R10 live INIT low", v, 32'h0);
    chk("R6 masked event gives no irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk); init_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R3 INIT rise sets bit 1", v, 32'h3);
  endtask

  task automatic t_mask;
    wr(2'd1, ~32'h1);
    chk("R6 unmasked bit 0 raises irq", {31'b0, irq_o}, 32'h1);
    wr(2'd1, ~32'h4);
    chk("R6 only bit 2 unmasked, not set", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c;
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R4 writing 0 keeps bits", v, 32'h3);
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk("R4 writing 1 clears bit 0 only", v, 32'h2);
  endtask

  task automatic t_events;
    pulse(13);
    pulse(2);
    rd(2'd0, v); chk("R2 events set bits 13 and 2", v, 32'h2006);
    chk("R6 bit 2 unmasked raises irq", {31'b0, irq_o}, 32'h1);
    pulse(19);
    rd(2'd0, v); chk("R2 unimplemented bit 19 reads 0", v, 32'h2006);
    wr(2'd0, IMPL);
    rd(2'd0, v); chk("R4 clear all", v, 32'h0);
    chk("R7 err low when clear", {31'b0, err_o}, 32'h0);
    pulse(2);
    chk("R7 bit 2 is not an error", {31'b0, err_o}, 32'h0);
    pulse(22);
    chk("R7 bit 22 raises err", {31'b0, err_o}, 32'h1);
    wr(2'd0, 32'h0040_0000);
    chk("R7 err drops after clear", {31'b0, err_o}, 32'h0);
  endtask

  task automatic t_collision;
    @(negedge clk); evt_i[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h4;
    @(negedge clk);
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    evt_i[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R5 event wins over same-cycle clear", {31'b0, v[2]}, 32'h1);
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk("R4 later clear removes bit 2", {31'b0, v[2]}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    init_i = 1'b1; evt_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_guard();
    t_init();
    t_mask();
    t_w1c();
    t_events();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule